// File: doc/BRIEF.md
# Store Ordering Queue with Load Hazard Gate

This block keeps the stores of a speculative out-of-order core in program order and decides when a load may start its memory access. Each store takes an entry at the tail of a circular queue when it is dispatched and gets back a tag. The tag is the entry index plus a wrap bit. The effective address and the store data arrive later, addressed by entry index. A store writes memory only when the reorder buffer reports that this store is the oldest instruction. Memory therefore changes strictly in program order.

A load presents its address and an age tag. The age tag is the value of the store tail when the load was dispatched, so every store with a smaller position is older than the load. The load is held while any older live store has an unknown address or the same address. It is released once those stores have retired. A flush cuts the queue back to a given tag in one cycle. Stores younger than the flush point disappear, and their slots are handed out again.

Top module: `store_order_queue`

## Requirements
- R1: After reset the queue is empty: `sq_full_o` is 0, `sq_tag_o` is 0, no memory write is issued, and any load request is granted (`ld_go_o`=1, `ld_hold_o`=0).
- R2: An allocate request is accepted only when the queue is not full and no flush is present. `sq_tag_o` shows the tail tag {wrap bit, index} before the allocation and steps by one per accepted store. With 8 live stores `sq_full_o` is 1, and a further allocate leaves the tag unchanged.
- R3: An address update writes the address and data into the entry selected by `st_idx_i` and marks that entry's address as known.
- R4: A commit of a head store whose address is known drives `mem_we_o` in the same cycle with that store's address and data, and frees the head. Successive commits write in allocation order.
- R5: A load is held while an older live store has a known address equal to the load address over all 32 bits. It is granted when every older known address differs.
- R6: A load is held while any older live store still has an unknown address.
- R7: Stores at or after the load's age tag never hold the load.
- R8: A load held only by a store becomes granted in the cycle after that store commits.
- R9: A flush removes every store from `fl_tag_i` up to the tail in one cycle and sets the tail tag to `fl_tag_i`. Later allocations reuse those slots with their addresses unknown.
- R10: An allocate request in the same cycle as a flush is ignored.
- R11: A commit when the queue is empty, or when the head store's address is unknown, writes nothing and leaves the head in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_alloc_i | input | 1 | Allocate a store entry at the tail |
| sq_full_o | output | 1 | All entries are live |
| sq_tag_o | output | 4 | Tail tag {wrap, index} given to the next store |
| st_upd_i | input | 1 | Address and data update for an entry |
| st_idx_i | input | 3 | Entry index for the update |
| st_addr_i | input | 32 | Store effective address |
| st_data_i | input | 32 | Store data |
| commit_i | input | 1 | Reorder-buffer head is the oldest store |
| fl_i | input | 1 | Flush stores from `fl_tag_i` onward |
| fl_tag_i | input | 4 | First tag removed by the flush |
| ld_req_i | input | 1 | Load asks to start its memory access |
| ld_addr_i | input | 32 | Load effective address |
| ld_age_i | input | 4 | Store tail tag seen when the load was dispatched |
| ld_go_o | output | 1 | Load may access memory |
| ld_hold_o | output | 1 | Load must wait |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Memory write address |
| mem_wdata_o | output | 32 | Memory write data |

## Verification
Loads are tried against an older store with the same address, against one that differs only in the top address bit, and against one whose address is still missing. This separates a full address compare from a partial one, and it separates blocking on an unknown address from blocking on a match. The same address is also presented with an age tag below the matching store, which shows that younger stores are excluded. A queue filled to capacity across the wrap point, then cut back by a flush while an allocate is requested, shows that the wrap-bit arithmetic is correct, that reused slots start with an unknown address, and that the writes come out in order against a scoreboard of expected writes.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int unsigned SQ_DEPTH = 8;
  localparam int unsigned SQ_AW    = 32;
  localparam int unsigned SQ_DW    = 32;

  typedef struct packed {
    logic live;
    logic known;
  } sq_flags_t;
endpackage

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_i,
  input  logic          commit_ok_i,
  input  logic          fl_i,
  input  logic [PW-1:0] fl_tag_i,
  output logic [PW-1:0] head_o,
  output logic [PW-1:0] tail_o,
  output logic          full_o,
  output logic          alloc_fire_o
);
  logic [PW-1:0] head_q, head_d, tail_q, tail_d, count;
  logic          head_en, tail_en;

  always_comb begin
    count        = tail_q - head_q;
    full_o       = count[IW];
    alloc_fire_o = alloc_i && !count[IW] && !fl_i;
    head_en      = commit_ok_i;
    head_d       = head_q + PW'(1);
    tail_en      = fl_i || alloc_fire_o;
    tail_d       = fl_i ? fl_tag_i : tail_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (head_en) head_q <= head_d;
      if (tail_en) tail_q <= tail_d;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q - head_q) <= PW'(DEPTH));

  p_alloc_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && full_o && !fl_i) |=> (tail_q == $past(tail_q)));

  p_flush_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_i |=> (tail_o == $past(fl_tag_i)));

  p_flush_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_i |-> ((fl_tag_i - head_q) <= count));
endmodule

// File: rtl/sq_entry_array.sv
module sq_entry_array
  import sq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_fire_i,
  input  logic [IW-1:0]             tail_idx_i,
  input  logic [IW-1:0]             head_idx_i,
  input  logic                      upd_i,
  input  logic [IW-1:0]             upd_idx_i,
  input  logic [AW-1:0]             upd_addr_i,
  input  logic [DW-1:0]             upd_data_i,
  input  logic                      commit_ok_i,
  input  logic                      fl_i,
  input  logic [PW-1:0]             fl_keep_i,
  output sq_flags_t [DEPTH-1:0]     flags_o,
  output logic [DEPTH-1:0][AW-1:0]  addr_o,
  output logic [DEPTH-1:0][DW-1:0]  data_o
);
  sq_flags_t [DEPTH-1:0] flags_q, flags_d;
  logic [DEPTH-1:0]      flags_en;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [IW-1:0] off;
    logic          cut, pay_en;

    always_comb begin
      off         = IW'(i) - head_idx_i;
      cut         = fl_i && ({1'b0, off} >= fl_keep_i);
      pay_en      = upd_i && (upd_idx_i == IW'(i));
      flags_d[i]  = flags_q[i];
      flags_en[i] = 1'b0;
      if (cut) begin
        flags_d[i]  = '0;
        flags_en[i] = 1'b1;
      end else if (commit_ok_i && head_idx_i == IW'(i)) begin
        flags_d[i]  = '0;
        flags_en[i] = 1'b1;
      end else if (alloc_fire_i && tail_idx_i == IW'(i)) begin
        flags_d[i].live  = 1'b1;
        flags_d[i].known = 1'b0;
        flags_en[i]      = 1'b1;
      end else if (pay_en) begin
        flags_d[i].known = 1'b1;
        flags_en[i]      = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[i] <= '0;
      end else if (flags_en[i]) begin
        flags_q[i] <= flags_d[i];
      end
    end

    always_ff @(posedge clk) begin
      if (pay_en) begin
        addr_o[i] <= upd_addr_i;
        data_o[i] <= upd_data_i;
      end
    end
  end

  assign flags_o = flags_q;

  p_free_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok_i |=> !flags_q[$past(head_idx_i)].live);

  p_alloc_unknown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire_i && !fl_i) |=> !flags_q[$past(tail_idx_i)].known);
endmodule

// File: rtl/sq_load_gate.sv
module sq_load_gate
  import sq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  sq_flags_t [DEPTH-1:0]    flags_i,
  input  logic [DEPTH-1:0][AW-1:0] addr_i,
  input  logic [PW-1:0]            head_i,
  input  logic                     ld_req_i,
  input  logic [AW-1:0]            ld_addr_i,
  input  logic [PW-1:0]            ld_age_i,
  output logic                     ld_go_o,
  output logic                     ld_hold_o
);
  logic [PW-1:0]    limit;
  logic [DEPTH-1:0] blk;

  assign limit = ld_age_i - head_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [IW-1:0] off;
    logic          older;
    always_comb begin
      off    = IW'(i) - head_i[IW-1:0];
      older  = flags_i[i].live && ({1'b0, off} < limit);
      blk[i] = older && (!flags_i[i].known || addr_i[i] == ld_addr_i);
    end
  end

  assign ld_go_o   = ld_req_i && !(|blk);
  assign ld_hold_o = ld_req_i && (|blk);

  p_young_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req_i && ld_age_i == head_i) |-> ld_go_o);
endmodule

// File: rtl/store_order_queue.sv
module store_order_queue
  import sq_pkg::*;
#(
  parameter int unsigned DEPTH = SQ_DEPTH,
  parameter int unsigned AW    = SQ_AW,
  parameter int unsigned DW    = SQ_DW,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_alloc_i,
  output logic          sq_full_o,
  output logic [PW-1:0] sq_tag_o,
  input  logic          st_upd_i,
  input  logic [IW-1:0] st_idx_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          commit_i,
  input  logic          fl_i,
  input  logic [PW-1:0] fl_tag_i,
  input  logic          ld_req_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [PW-1:0] ld_age_i,
  output logic          ld_go_o,
  output logic          ld_hold_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  logic [1:0]               rst_sync_q;
  logic                     rst_ni;
  logic [PW-1:0]            head, tail;
  logic                     alloc_fire, commit_ok;
  sq_flags_t [DEPTH-1:0]    flags;
  logic [DEPTH-1:0][AW-1:0] addr;
  logic [DEPTH-1:0][DW-1:0] data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign commit_ok = commit_i && flags[head[IW-1:0]].live && flags[head[IW-1:0]].known;

  sq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_ni),
    .alloc_i     (st_alloc_i),
    .commit_ok_i (commit_ok),
    .fl_i        (fl_i),
    .fl_tag_i    (fl_tag_i),
    .head_o      (head),
    .tail_o      (tail),
    .full_o      (sq_full_o),
    .alloc_fire_o(alloc_fire)
  );

  sq_entry_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_arr (
    .clk         (clk),
    .rst_n       (rst_ni),
    .alloc_fire_i(alloc_fire),
    .tail_idx_i  (tail[IW-1:0]),
    .head_idx_i  (head[IW-1:0]),
    .upd_i       (st_upd_i),
    .upd_idx_i   (st_idx_i),
    .upd_addr_i  (st_addr_i),
    .upd_data_i  (st_data_i),
    .commit_ok_i (commit_ok),
    .fl_i        (fl_i),
    .fl_keep_i   (fl_tag_i - head),
    .flags_o     (flags),
    .addr_o      (addr),
    .data_o      (data)
  );

  sq_load_gate #(.DEPTH(DEPTH), .AW(AW)) u_gate (
    .clk      (clk),
    .rst_n    (rst_ni),
    .flags_i  (flags),
    .addr_i   (addr),
    .head_i   (head),
    .ld_req_i (ld_req_i),
    .ld_addr_i(ld_addr_i),
    .ld_age_i (ld_age_i),
    .ld_go_o  (ld_go_o),
    .ld_hold_o(ld_hold_o)
  );

  assign sq_tag_o    = tail;
  assign mem_we_o    = commit_ok;
  assign mem_addr_o  = addr[head[IW-1:0]];
  assign mem_wdata_o = data[head[IW-1:0]];

  p_skip_commit_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (commit_i && !mem_we_o) |=> (head == $past(head)));

  p_write_step_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we_o |=> (head == $past(head) + PW'(1)));
endmodule

// File: tb/store_order_queue_tb.sv
module store_order_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_alloc_i, st_upd_i, commit_i, fl_i, ld_req_i;
  logic [2:0]  st_idx_i;
  logic [31:0] st_addr_i, st_data_i, ld_addr_i;
  logic [3:0]  fl_tag_i, ld_age_i;
  logic        sq_full_o, ld_go_o, ld_hold_o, mem_we_o;
  logic [3:0]  sq_tag_o;
  logic [31:0] mem_addr_o, mem_wdata_o;

  int tests = 0;
  int fails = 0;
  logic [63:0] exp_q[$];

  always #10 clk = ~clk;

  store_order_queue u_dut (
    .clk(clk), .rst_n(rst_n), .st_alloc_i(st_alloc_i), .sq_full_o(sq_full_o),
    .sq_tag_o(sq_tag_o), .st_upd_i(st_upd_i), .st_idx_i(st_idx_i),
    .st_addr_i(st_addr_i), .st_data_i(st_data_i), .commit_i(commit_i),
    .fl_i(fl_i), .fl_tag_i(fl_tag_i), .ld_req_i(ld_req_i), .ld_addr_i(ld_addr_i),
    .ld_age_i(ld_age_i), .ld_go_o(ld_go_o), .ld_hold_o(ld_hold_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  function automatic logic [31:0] dat(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: every memory write must match the next expected item
  always @(negedge clk) begin
    if (rst_n && mem_we_o) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R4: actual write %0h expected none", mem_addr_o);
      end else begin
        chk("R4 write order", {mem_addr_o, mem_wdata_o}, exp_q.pop_front());
      end
    end
  end

  task automatic nxt();
    @(posedge clk); #1;
  endtask

  task automatic alloc(input logic [3:0] exp_tag, input string req);
    st_alloc_i = 1'b1;
    @(negedge clk);
    chk(req, sq_tag_o, exp_tag);
    nxt();
    st_alloc_i = 1'b0;
  endtask

  task automatic upd(input logic [2:0] idx, input logic [31:0] a);
    st_upd_i = 1'b1; st_idx_i = idx; st_addr_i = a; st_data_i = dat(a);
    nxt();
    st_upd_i = 1'b0;
  endtask

  task automatic ld(input logic [31:0] a, input logic [3:0] age, input logic go, input string req);
    ld_req_i = 1'b1; ld_addr_i = a; ld_age_i = age;
    @(negedge clk);
    chk(req, {ld_go_o, ld_hold_o}, {go, ~go});
    nxt();
    ld_req_i = 1'b0;
  endtask

  // Driver: pushes the expected write before the commit cycle
  task automatic commit(input logic wr, input logic [31:0] a, input string req);
    if (wr) exp_q.push_back({a, dat(a)});
    commit_i = 1'b1;
    @(negedge clk);
    chk(req, mem_we_o, wr);
    nxt();
    commit_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    st_alloc_i = 0; st_upd_i = 0; commit_i = 0; fl_i = 0; ld_req_i = 0;
    st_idx_i = 0; st_addr_i = 0; st_data_i = 0; ld_addr_i = 0;
    fl_tag_i = 0; ld_age_i = 0;
    repeat (3) nxt();
    rst_n = 1'b1;
    repeat (4) nxt();

    // R1 reset state
    chk("R1 full", sq_full_o, 0);
    chk("R1 tag", sq_tag_o, 0);
    chk("R1 no write", mem_we_o, 0);
    ld(32'h100, 4'd0, 1'b1, "R1 load granted");
    commit(1'b0, 0, "R11 empty commit");

    // R2 allocation order, R3 address capture
    alloc(4'd0, "R2 tag0");
    alloc(4'd1, "R2 tag1");
    alloc(4'd2, "R2 tag2");
    upd(3'd0, 32'h100);
    upd(3'd2, 32'h200);

    ld(32'h100, 4'd0, 1'b1, "R7 younger store ignored");
    ld(32'h100, 4'd1, 1'b0, "R5 same address held");
    ld(32'h300, 4'd1, 1'b1, "R5 other address granted");
    ld(32'h8000_0100, 4'd1, 1'b1, "R5 top bit differs");
    ld(32'h300, 4'd2, 1'b0, "R6 unknown address held");
    upd(3'd1, 32'h300);
    ld(32'h300, 4'd2, 1'b0, "R3 R5 updated address held");
    ld(32'h400, 4'd3, 1'b1, "R5 no match granted");
    ld(32'h200, 4'd3, 1'b0, "R5 third store matches");

    // R8 release after commit
    ld_req_i = 1'b1; ld_addr_i = 32'h100; ld_age_i = 4'd1;
    exp_q.push_back({32'h100, dat(32'h100)});
    commit_i = 1'b1;
    @(negedge clk);
    chk("R8 held during commit", ld_go_o, 0);
    chk("R4 commit write", mem_we_o, 1);
    nxt();
    commit_i = 1'b0;
    @(negedge clk);
    chk("R8 granted after commit", ld_go_o, 1);
    nxt();
    ld_req_i = 1'b0;

    // R11 unknown head
    alloc(4'd3, "R2 tag3");
    commit(1'b1, 32'h300, "R4 second write");
    commit(1'b1, 32'h200, "R4 third write");
    commit(1'b0, 0, "R11 unknown head no write");
    upd(3'd3, 32'h400);
    commit(1'b1, 32'h400, "R11 head written once known");
    chk("R1 R4 empty again", sq_tag_o, 4'd4);

    // Fill across the wrap point
    for (int k = 0; k < 8; k++) alloc(4'(4 + k), "R2 wrap tags");
    chk("R2 full", sq_full_o, 1);
    alloc(4'd12, "R2 alloc when full");
    chk("R2 tag unchanged when full", sq_tag_o, 4'd12);
    for (int k = 4; k < 8; k++) upd(3'(k), 32'h1000 + 32'(k) * 4);
    upd(3'd0, 32'h3000);
    upd(3'd1, 32'h3004);
    upd(3'd2, 32'h2000);
    upd(3'd3, 32'h2000);
    ld(32'h2000, 4'd12, 1'b0, "R5 wrapped match held");
    ld(32'h2000, 4'd10, 1'b1, "R7 wrapped younger ignored");

    // R9 flush with R10 concurrent allocate
    fl_i = 1'b1; fl_tag_i = 4'd10; st_alloc_i = 1'b1;
    nxt();
    fl_i = 1'b0; st_alloc_i = 1'b0;
    @(negedge clk);
    chk("R9 R10 tail after flush", sq_tag_o, 4'd10);
    chk("R9 not full", sq_full_o, 0);
    nxt();
    alloc(4'd10, "R9 slot reused");
    ld(32'h2000, 4'd11, 1'b0, "R9 reused slot unknown");
    upd(3'd2, 32'h5000);
    ld(32'h2000, 4'd11, 1'b1, "R9 flushed store gone");

    for (int k = 4; k < 8; k++) commit(1'b1, 32'h1000 + 32'(k) * 4, "R4 ordered commits");
    commit(1'b1, 32'h3000, "R4 commit tag8");
    commit(1'b1, 32'h3004, "R4 commit tag9");
    commit(1'b1, 32'h5000, "R4 commit tag10");
    commit(1'b0, 0, "R11 empty after drain");
    chk("R4 all writes seen", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule